// File: doc/BRIEF.md
# Edge-to-Edge Delay Meter

The block watches two single-bit inputs, a reference and a response, and samples both once per cycle of its own, faster clock. Every cycle is one sample, and a free-running sample index counts the samples. When a selected reference edge arrives, the block opens a measurement at the current index. The next selected response edge closes it. The difference of the two indices is reported on a data output, together with a valid strobe that lasts one cycle.

The pairing uses a two-state machine: waiting for a reference edge, and waiting for a response edge. An edge that arrives while the machine is in the other state is counted as missed, in a saturating counter for each input, and each increment also raises a one-cycle pulse. A single sample can close one measurement and open the next, or open and close one with zero delay. Each input has its own edge-polarity setting, which is taken while reset is asserted. Conversion of the result to time units and synchronisation of the inputs are left to the surroundings.

Top module: `edge_delay_meter`

## Requirements
- R1: Polarity codes for `ref_pol` and `rsp_pol`:
  - 2'b00 selects rising edges only.
  - 2'b01 selects falling edges only.
  - 2'b10 and 2'b11 select any change of level.
  - Edges that are not selected have no effect on the machine, the measurement or the counters.
- R2: After reset the outputs are zero and the machine waits for a reference edge.
- R3: A reference edge followed d samples later by a response edge gives `meas_delay` = d. This value appears, with `meas_valid` high for one cycle, in the cycle after the response edge is sampled. `meas_delay` then holds until the next measurement.
- R4: While the machine waits for a reference edge, a reference edge and a response edge in the same sample produce a measurement with delay 0.
- R5: While the machine waits for a response edge, a reference edge increments `miss_ref_cnt` and leaves the start index of the open measurement unchanged.
- R6: While the machine waits for a reference edge, a response edge increments `miss_rsp_cnt`, but only once at least one measurement has completed since reset.
- R7: While the machine waits for a response edge, a response edge and a reference edge in the same sample close the current measurement and open a new one at that sample. Neither miss counter changes.
- R8: The first sample after reset only loads the previous-value registers, so no edge is detected on that sample.
- R9: Both miss counters saturate at their maximum value.
- R10: `miss_ref_pulse` and `miss_rsp_pulse` are high for one cycle exactly when the matching counter increments.
- R11: The polarity inputs are taken only while `rst` is high. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pol | input | 2 | Reference edge polarity (taken during reset) |
| rsp_pol | input | 2 | Response edge polarity (taken during reset) |
| ref_in | input | 1 | Reference input |
| rsp_in | input | 1 | Response input |
| meas_valid | output | 1 | One-cycle strobe for a new measurement |
| meas_delay | output | IDX_W | Delay in samples, held between measurements |
| miss_ref_cnt | output | CNT_W | Saturating count of out-of-turn reference edges |
| miss_ref_pulse | output | 1 | Pulse on each increment of `miss_ref_cnt` |
| miss_rsp_cnt | output | CNT_W | Saturating count of out-of-turn response edges |
| miss_rsp_pulse | output | 1 | Pulse on each increment of `miss_rsp_cnt` |

## Verification
The assertions check the following on every cycle:
- `meas_delay` changes only together with the strobe.
- Each miss pulse matches a single-step increment of its counter.
- Full counters stay full.
- No response miss is counted before the first measurement.
- The first sample after reset produces nothing.
- The stored polarity stays frozen outside reset.

Only the bench scenarios can show that the reported delay equals the sample distance for every polarity pairing, and how the same-sample open/close cases resolve. They also show that unselected edges are ignored and that live changes to the polarity inputs are disregarded.

// File: rtl/edge_delay_meter.sv
module edge_delay_meter #(
  parameter int IDX_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ref_pol,
  input  logic [1:0]       rsp_pol,
  input  logic             ref_in,
  input  logic             rsp_in,
  output logic             meas_valid,
  output logic [IDX_W-1:0] meas_delay,
  output logic [CNT_W-1:0] miss_ref_cnt,
  output logic             miss_ref_pulse,
  output logic [CNT_W-1:0] miss_rsp_cnt,
  output logic             miss_rsp_pulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic {WAIT_REF = 1'b0, WAIT_RSP = 1'b1} state_t;

  state_t           state, state_nx;
  logic [1:0]       ref_pol_q, rsp_pol_q;
  logic             primed, ref_prev, rsp_prev, rsp_seen;
  logic [IDX_W-1:0] idx, start_idx;
  logic             ref_ev, rsp_ev;
  logic             open_m, close_m, miss_ref, miss_rsp;
  logic             inc_ref, inc_rsp;

  function automatic logic sel_edge(input logic [1:0] pol, input logic prev, input logic cur);
    case (pol)
      2'b00:   sel_edge = !prev && cur;
      2'b01:   sel_edge = prev && !cur;
      default: sel_edge = prev ^ cur;
    endcase
  endfunction

  assign ref_ev = primed && sel_edge(ref_pol_q, ref_prev, ref_in);
  assign rsp_ev = primed && sel_edge(rsp_pol_q, rsp_prev, rsp_in);

  assign close_m  = (state == WAIT_RSP) ? rsp_ev : (ref_ev && rsp_ev);
  assign open_m   = ref_ev && ((state == WAIT_REF) || rsp_ev);
  assign miss_ref = (state == WAIT_RSP) && ref_ev && !rsp_ev;
  assign miss_rsp = (state == WAIT_REF) && rsp_ev && !ref_ev && rsp_seen;
  assign inc_ref  = miss_ref && (miss_ref_cnt != CNT_MAX);
  assign inc_rsp  = miss_rsp && (miss_rsp_cnt != CNT_MAX);

  always_comb begin
    state_nx = state;
    if (state == WAIT_REF) begin
      if (ref_ev && !rsp_ev) state_nx = WAIT_RSP;
    end else if (rsp_ev) begin
      state_nx = ref_ev ? WAIT_RSP : WAIT_REF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_pol_q      <= ref_pol;
      rsp_pol_q      <= rsp_pol;
      state          <= WAIT_REF;
      primed         <= 1'b0;
      ref_prev       <= 1'b0;
      rsp_prev       <= 1'b0;
      rsp_seen       <= 1'b0;
      idx            <= '0;
      start_idx      <= '0;
      meas_valid     <= 1'b0;
      meas_delay     <= '0;
      miss_ref_cnt   <= '0;
      miss_rsp_cnt   <= '0;
      miss_ref_pulse <= 1'b0;
      miss_rsp_pulse <= 1'b0;
    end else begin
      primed         <= 1'b1;
      ref_prev       <= ref_in;
      rsp_prev       <= rsp_in;
      idx            <= idx + 1'b1;
      state          <= state_nx;
      rsp_seen       <= rsp_seen || close_m;
      meas_valid     <= close_m;
      miss_ref_pulse <= inc_ref;
      miss_rsp_pulse <= inc_rsp;
      if (open_m)  start_idx <= idx;
      if (close_m) meas_delay <= (state == WAIT_RSP) ? idx - start_idx : '0;
      if (inc_ref) miss_ref_cnt <= miss_ref_cnt + 1'b1;
      if (inc_rsp) miss_rsp_cnt <= miss_rsp_cnt + 1'b1;
    end
  end

  assert_delay_held_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(meas_delay) |-> meas_valid);

  assert_ref_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    miss_ref_pulse |-> miss_ref_cnt == $past(miss_ref_cnt) + 1'b1);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    miss_rsp_pulse |-> miss_rsp_cnt == $past(miss_rsp_cnt) + 1'b1);

  assert_ref_sat_R9: assert property (@(posedge clk) disable iff (rst)
    miss_ref_cnt == CNT_MAX |=> miss_ref_cnt == CNT_MAX);

  assert_rsp_sat_R9: assert property (@(posedge clk) disable iff (rst)
    miss_rsp_cnt == CNT_MAX |=> miss_rsp_cnt == CNT_MAX);

  assert_no_early_rsp_miss_R6: assert property (@(posedge clk) disable iff (rst)
    !rsp_seen |-> miss_rsp_cnt == '0);

  assert_first_sample_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !primed |=> !meas_valid && !miss_ref_pulse && !miss_rsp_pulse);

  assert_pol_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    primed |-> $stable(ref_pol_q) && $stable(rsp_pol_q));

endmodule

// File: tb/edge_delay_meter_tb.sv
module edge_delay_meter_tb;
  localparam int IDX_W = 32;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ref_pol = 2'b00, rsp_pol = 2'b00;
  logic ref_in = 1'b0, rsp_in = 1'b0;
  logic meas_valid, miss_ref_pulse, miss_rsp_pulse;
  logic [IDX_W-1:0] meas_delay;
  logic [CNT_W-1:0] miss_ref_cnt, miss_rsp_cnt;

  int checks = 0, failures = 0, nstep = 0, t0 = 0;
  int rm = 0, sm = 0;

  always #2 clk = ~clk;

  edge_delay_meter #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ref_pol(ref_pol), .rsp_pol(rsp_pol),
    .ref_in(ref_in), .rsp_in(rsp_in), .meas_valid(meas_valid),
    .meas_delay(meas_delay), .miss_ref_cnt(miss_ref_cnt),
    .miss_ref_pulse(miss_ref_pulse), .miss_rsp_cnt(miss_rsp_cnt),
    .miss_rsp_pulse(miss_rsp_pulse));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    nstep++;
  endtask

  task automatic do_reset(input int r, input int s);
    rm = r; sm = s;
    rst = 1'b1;
    ref_pol = 2'(r); rsp_pol = 2'(s);
    step(); step();
    rst = 1'b0;
    step();
  endtask

  task automatic prep_ref();
    if (rm == 0 && ref_in) begin ref_in = 1'b0; step(); end
    else if (rm == 1 && !ref_in) begin ref_in = 1'b1; step(); end
  endtask

  task automatic prep_rsp();
    if (sm == 0 && rsp_in) begin rsp_in = 1'b0; step(); end
    else if (sm == 1 && !rsp_in) begin rsp_in = 1'b1; step(); end
  endtask

  task automatic measure(input int d);
    prep_ref(); prep_rsp();
    ref_in = ~ref_in;
    if (d == 0) begin
      rsp_in = ~rsp_in;
      step();
      check(meas_valid == 1'b1, "R4 valid", meas_valid, 1);
      check(meas_delay == 0, "R4 delay", meas_delay, 0);
    end else begin
      repeat (d) step();
      rsp_in = ~rsp_in;
      step();
      check(meas_valid == 1'b1, "R3 valid", meas_valid, 1);
      check(meas_delay == IDX_W'(d), "R3 delay", meas_delay, d);
    end
    step();
    check(meas_valid == 1'b0, "R3 strobe one cycle", meas_valid, 0);
    check(meas_delay == IDX_W'(d), "R3 delay held", meas_delay, d);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", nstep, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R2 reset state
    do_reset(0, 0);
    check(meas_valid == 0 && miss_ref_pulse == 0 && miss_rsp_pulse == 0, "R2 strobes", meas_valid, 0);
    check(meas_delay == 0, "R2 delay", meas_delay, 0);
    check(miss_ref_cnt == 0 && miss_rsp_cnt == 0, "R2 counters", miss_ref_cnt, 0);

    // R3/R4/R1 sweep over all polarity pairings and small delays
    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s < 3; s++) begin
        do_reset(r, s);
        for (int d = 0; d < 5; d++) measure(d);
        check(miss_ref_cnt == 0, "R1 unselected edges ignored (ref)", miss_ref_cnt, 0);
        check(miss_rsp_cnt == 0, "R1 unselected edges ignored (rsp)", miss_rsp_cnt, 0);
      end
    end

    // R1 explicit: rising mode ignores falling reference edge mid-measurement
    ref_in = 1'b0; rsp_in = 1'b0;
    do_reset(0, 0);
    ref_in = 1'b1; step(); t0 = nstep;
    ref_in = 1'b0; step();
    check(miss_ref_cnt == 0 && !miss_ref_pulse, "R1 falling ignored", miss_ref_cnt, 0);
    rsp_in = 1'b1; step();
    check(meas_valid && meas_delay == IDX_W'(nstep - t0), "R1 delay", meas_delay, nstep - t0);

    // R5 / R10 missed reference
    do_reset(2, 2);
    ref_in = ~ref_in; step(); t0 = nstep;
    ref_in = ~ref_in; step();
    check(miss_ref_pulse == 1'b1, "R10 ref pulse", miss_ref_pulse, 1);
    check(miss_ref_cnt == 1, "R5 ref miss count", miss_ref_cnt, 1);
    step();
    check(miss_ref_pulse == 1'b0, "R10 ref pulse one cycle", miss_ref_pulse, 0);
    rsp_in = ~rsp_in; step();
    check(meas_valid && meas_delay == IDX_W'(nstep - t0), "R5 start unchanged", meas_delay, nstep - t0);

    // R6 response miss only after a completed measurement
    do_reset(2, 2);
    rsp_in = ~rsp_in; step();
    check(miss_rsp_cnt == 0 && !miss_rsp_pulse, "R6 no miss before measurement", miss_rsp_cnt, 0);
    measure(2);
    rsp_in = ~rsp_in; step();
    check(miss_rsp_pulse == 1'b1, "R10 rsp pulse", miss_rsp_pulse, 1);
    check(miss_rsp_cnt == 1, "R6 rsp miss count", miss_rsp_cnt, 1);

    // R7 close and reopen in one sample
    do_reset(2, 2);
    ref_in = ~ref_in; step();
    step();
    ref_in = ~ref_in; rsp_in = ~rsp_in; step(); t0 = nstep;
    check(meas_valid && meas_delay == 2, "R7 close", meas_delay, 2);
    check(miss_ref_cnt == 0 && miss_rsp_cnt == 0, "R7 no miss", miss_ref_cnt, 0);
    step();
    rsp_in = ~rsp_in; step();
    check(meas_valid && meas_delay == IDX_W'(nstep - t0), "R7 reopened", meas_delay, nstep - t0);

    // R8 first sample after reset
    ref_in = 1'b0; rsp_in = 1'b0;
    rst = 1'b1; ref_pol = 2'b10; rsp_pol = 2'b10; rm = 2; sm = 2;
    step(); step();
    ref_in = 1'b1; rsp_in = 1'b1;
    step();
    rst = 1'b0;
    step();
    check(meas_valid == 1'b0, "R8 no edge on first sample", meas_valid, 0);
    step();
    check(meas_valid == 1'b0 && meas_delay == 0, "R8 still idle", meas_delay, 0);

    // R9 saturation
    do_reset(2, 2);
    measure(1);
    for (int k = 0; k < 20; k++) begin
      rsp_in = ~rsp_in; step();
      check(miss_rsp_pulse == (k < 15), "R9 pulse at saturation", miss_rsp_pulse, (k < 15));
      check(miss_rsp_cnt == CNT_W'((k < 15) ? k + 1 : 15), "R9 count", miss_rsp_cnt, (k < 15) ? k + 1 : 15);
    end

    // R11 polarity taken only in reset
    ref_in = 1'b0; rsp_in = 1'b0;
    do_reset(0, 0);
    ref_pol = 2'b01; rsp_pol = 2'b01;
    ref_in = 1'b1; step();
    rsp_in = 1'b1; step();
    check(meas_valid && meas_delay == 1, "R11 rising kept", meas_delay, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule